// File: doc/BRIEF.md
# Display Run/Update Sequencer

This block is the control core of a display pipeline. It holds a staged copy and an active copy of one configuration word. It decodes one-shot run, stop and update commands, and it keeps a sticky interrupt status with enable and clear registers. Software reaches all of this through a simple synchronous register port: one write strobe, a word index and data. Reads are combinational on the index. The pixel datapath and the timing generator sit outside the block. They report back through a frame-boundary strobe, two tearing-effect strobes and an underflow strobe.

There are two ways to commit configuration, selected by a mode bit. In continuous-video mode the block scans without pause once started. An update request moves the staged word into the active word at the next frame boundary, or at once if scanning is stopped. In command mode there is no staging. The staged word becomes active only when a run command starts a single frame. That frame can be held until a tearing-effect pulse arrives from a selectable source.

Top module: `disp_seq`

## Requirements
- R1: A write to index 0 is a one-shot command word: bit 0 run, bit 1 stop, bit 2 update. Nothing is stored. A read of index 0 returns `scan_on` in bit 0 and zeros elsewhere.
- R2: Index 1 holds the mode bits. Bit 0 clear selects continuous-video mode and bit 0 set selects command mode. Bit 1 enables tearing-effect gating. Bit 2 picks the tearing-effect source: 1 means `te_pad`, 0 means `te_int`. The source that is not selected has no effect on status or on gating.
- R3: In command mode, `active_cfg` loads from the staged word (index 2) only on a run command while idle. Writes to the staged word at any other time leave `active_cfg` unchanged. A run command during a frame in flight is ignored.
- R4: In video mode while scanning, an update command is held pending. At the next `frame_end` strobe, `active_cfg` takes the staged word and status bit 4 sets.
- R5: In video mode while idle, an update command copies the staged word into `active_cfg` on the same clock edge and sets status bit 4.
- R6: In video mode, a run command starts scanning on the next cycle. Each `frame_end` while scanning sets status bit 5. A stop command ends scanning at the next `frame_end` and sets status bit 0. A `frame_end` while idle sets nothing.
- R7: In command mode with gating off, a run command raises `scan_on` on the next cycle. With gating on, `scan_on` waits for a pulse on the selected tearing-effect source. A `frame_end` during the frame drops `scan_on` and sets status bit 0.
- R8: The status bits are: bit 0 done, bit 1 tearing effect from the selected source, bit 2 underflow, bit 4 update done, bit 5 vsync. Bit 3 always reads 0. The bits are sticky and set whether or not they are enabled. Status is read at index 5.
- R9: Writing ones to index 4 clears the matching status bits, so 0xFF clears all of them. An event in the same cycle as its clear leaves that bit set.
- R10: `irq` is high exactly when some status bit is set and its enable bit (index 3) is also set.
- R11: After reset the block is idle in video mode, and `active_cfg`, the staged word, the enables, the status and `irq` are all zero.
- R12: In command mode, update and stop commands are ignored. `active_cfg` stays as it is and the frame in flight still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on `reg_addr` |
| frame_end | input | 1 | One-cycle frame-boundary strobe from the timing logic |
| te_int | input | 1 | Internal tearing-effect strobe |
| te_pad | input | 1 | Tearing-effect strobe from the external pad |
| underflow | input | 1 | One-cycle pixel underflow strobe |
| irq | output | 1 | Interrupt request |
| scan_on | output | 1 | Output scanning is active |
| active_cfg | output | DATA_W | Configuration word used by the pipeline |

## Verification
The checks assume that `frame_end`, `te_int`, `te_pad` and `underflow` are single-cycle strobes synchronous to `clk`. They also assume the mode bits change only while the block is idle, and that the enable register is never rewritten on the same edge as an event it masks. The bench drives every strobe for exactly one cycle, away from the active edge. It writes the mode register only after scanning has finished, and it writes the enables only in cycles with no event strobe.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;

    localparam int IRQ_W = 6;

    localparam int A_CTRL  = 0;
    localparam int A_MODE  = 1;
    localparam int A_STAGE = 2;
    localparam int A_IEN   = 3;
    localparam int A_ICLR  = 4;
    localparam int A_ISTS  = 5;
    localparam int A_ACT   = 6;

    localparam int S_DONE  = 0;
    localparam int S_TE    = 1;
    localparam int S_UFLOW = 2;
    localparam int S_UPD   = 4;
    localparam int S_VSYNC = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VID,
        ST_WAIT_TE,
        ST_FRAME
    } seq_state_e;

    typedef struct packed {
        logic upd;
        logic stop;
        logic run;
    } ctrl_cmd_t;

    typedef struct packed {
        logic te_pad_sel;
        logic te_gate;
        logic cmd_mode;
    } mode_cfg_t;

    function automatic logic [IRQ_W-1:0] pack_events(
        input logic done, input logic te, input logic uflow,
        input logic upd, input logic vsync);
        logic [IRQ_W-1:0] v;
        v          = '0;
        v[S_DONE]  = done;
        v[S_TE]    = te;
        v[S_UFLOW] = uflow;
        v[S_UPD]   = upd;
        v[S_VSYNC] = vsync;
        return v;
    endfunction

endpackage

// File: rtl/disp_seq_regs.sv
module disp_seq_regs
    import disp_seq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output ctrl_cmd_t         cmd,
    output mode_cfg_t         mode,
    output logic [DATA_W-1:0] shadow,
    output logic [IRQ_W-1:0]  ien,
    output logic              clr_we,
    output logic [IRQ_W-1:0]  clr_mask
);

    logic wr_ctrl, wr_mode, wr_stage, wr_ien;

    always_comb begin
        wr_ctrl  = reg_we && (reg_addr == ADDR_W'(A_CTRL));
        wr_mode  = reg_we && (reg_addr == ADDR_W'(A_MODE));
        wr_stage = reg_we && (reg_addr == ADDR_W'(A_STAGE));
        wr_ien   = reg_we && (reg_addr == ADDR_W'(A_IEN));
        clr_we   = reg_we && (reg_addr == ADDR_W'(A_ICLR));
        clr_mask = reg_wdata[IRQ_W-1:0];
        cmd.run  = wr_ctrl && reg_wdata[0];
        cmd.stop = wr_ctrl && reg_wdata[1];
        cmd.upd  = wr_ctrl && reg_wdata[2];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= '0;
            shadow <= '0;
            ien    <= '0;
        end else begin
            if (wr_mode)  mode   <= mode_cfg_t'(reg_wdata[2:0]);
            if (wr_stage) shadow <= reg_wdata;
            if (wr_ien)   ien    <= reg_wdata[IRQ_W-1:0];
        end
    end

endmodule

// File: rtl/disp_seq_fsm.sv
module disp_seq_fsm
    import disp_seq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_cmd_t         cmd,
    input  mode_cfg_t         mode,
    input  logic [DATA_W-1:0] shadow,
    input  logic              frame_end,
    input  logic              te_int,
    input  logic              te_pad,
    output logic [DATA_W-1:0] active_cfg,
    output logic              scan_on,
    output logic              done_ev,
    output logic              te_ev,
    output logic              upd_ev,
    output logic              vsync_ev
);

    seq_state_e state;
    logic       upd_pend, stop_pend, te_sel;

    always_comb begin
        te_sel   = mode.te_pad_sel ? te_pad : te_int;
        te_ev    = te_sel;
        scan_on  = (state == ST_VID) || (state == ST_FRAME);
        vsync_ev = (state == ST_VID) && frame_end;
        done_ev  = ((state == ST_VID) && frame_end && stop_pend) ||
                   ((state == ST_FRAME) && frame_end);
        upd_ev   = ((state == ST_IDLE) && cmd.upd && !cmd.run && !mode.cmd_mode) ||
                   ((state == ST_VID) && frame_end && upd_pend);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            active_cfg <= '0;
            upd_pend   <= 1'b0;
            stop_pend  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    upd_pend  <= 1'b0;
                    stop_pend <= 1'b0;
                    if (cmd.run) begin
                        if (mode.cmd_mode) begin
                            active_cfg <= shadow;
                            state      <= mode.te_gate ? ST_WAIT_TE : ST_FRAME;
                        end else begin
                            state <= ST_VID;
                        end
                    end else if (upd_ev) begin
                        active_cfg <= shadow;
                    end
                end
                ST_VID: begin
                    if (frame_end) begin
                        if (upd_pend) begin
                            active_cfg <= shadow;
                            upd_pend   <= 1'b0;
                        end
                        if (stop_pend) begin
                            state     <= ST_IDLE;
                            stop_pend <= 1'b0;
                        end
                    end
                    if (cmd.upd)  upd_pend  <= 1'b1;
                    if (cmd.stop) stop_pend <= 1'b1;
                end
                ST_WAIT_TE: if (te_sel) state <= ST_FRAME;
                ST_FRAME:   if (frame_end) state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // R3: in command mode the active word only moves out of the idle state
    p_cmd_latch_r3: assert property (@(posedge clk) disable iff (rst)
        (mode.cmd_mode && $past(mode.cmd_mode) && (active_cfg != $past(active_cfg)))
            |-> ($past(state) == ST_IDLE));

    // R7: a gated frame stays parked until the selected strobe arrives
    p_te_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_WAIT_TE) && !te_sel) |=> (state == ST_WAIT_TE));

    // R6: scanning only ends together with a done event
    p_scan_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(scan_on) |-> $past(done_ev));

endmodule

// File: rtl/disp_seq_irq.sv
module disp_seq_irq
    import disp_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] ev,
    input  logic [IRQ_W-1:0] ien,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_mask,
    output logic [IRQ_W-1:0] status,
    output logic             irq
);

    logic [IRQ_W-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_we ? clr_mask : '0;
        irq     = |(status & ien);
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_eff) | ev;
    end

    // R8: a set status bit survives every cycle it is not cleared
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ((($past(status) & ~$past(clr_eff)) & ~status) == '0));

    // R10: an enabled event reaches the interrupt line on the next cycle
    p_irq_event_r10: assert property (@(posedge clk) disable iff (rst)
        (|($past(ev) & $past(ien) & ien)) |-> irq);

endmodule

// File: rtl/disp_seq.sv
module disp_seq
    import disp_seq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              frame_end,
    input  logic              te_int,
    input  logic              te_pad,
    input  logic              underflow,
    output logic              irq,
    output logic              scan_on,
    output logic [DATA_W-1:0] active_cfg
);

    ctrl_cmd_t         cmd;
    mode_cfg_t         mode;
    logic [DATA_W-1:0] shadow;
    logic [IRQ_W-1:0]  ien, clr_mask, status, ev;
    logic              clr_we, done_ev, te_ev, upd_ev, vsync_ev;

    disp_seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cmd(cmd), .mode(mode), .shadow(shadow),
        .ien(ien), .clr_we(clr_we), .clr_mask(clr_mask)
    );

    disp_seq_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk(clk), .rst(rst), .cmd(cmd), .mode(mode), .shadow(shadow),
        .frame_end(frame_end), .te_int(te_int), .te_pad(te_pad),
        .active_cfg(active_cfg), .scan_on(scan_on), .done_ev(done_ev),
        .te_ev(te_ev), .upd_ev(upd_ev), .vsync_ev(vsync_ev)
    );

    assign ev = pack_events(done_ev, te_ev, underflow, upd_ev, vsync_ev);

    disp_seq_irq irq_i (
        .clk(clk), .rst(rst), .ev(ev), .ien(ien), .clr_we(clr_we),
        .clr_mask(clr_mask), .status(status), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_CTRL):  reg_rdata[0]         = scan_on;
            ADDR_W'(A_MODE):  reg_rdata[2:0]       = mode;
            ADDR_W'(A_STAGE): reg_rdata            = shadow;
            ADDR_W'(A_IEN):   reg_rdata[IRQ_W-1:0] = ien;
            ADDR_W'(A_ISTS):  reg_rdata[IRQ_W-1:0] = status;
            ADDR_W'(A_ACT):   reg_rdata            = active_cfg;
            default:          reg_rdata            = '0;
        endcase
    end

endmodule

// File: tb/disp_seq_tb_top.sv
module disp_seq_tb_top;

    localparam int OP_WR = 0, OP_FE = 1, OP_TE = 2, OP_UF = 3;
    localparam int NV = 15;
    // {op[1:0], addr[2:0], data[31:0], exp_active[31:0], exp_status[5:0], exp_scan}
    localparam logic [75:0] VEC [NV] = '{
        {2'd0, 3'd2, 32'hA5A5_0001, 32'h0000_0000, 6'h00, 1'b0}, // R3 stage only
        {2'd0, 3'd0, 32'h0000_0004, 32'hA5A5_0001, 6'h10, 1'b0}, // R5 idle update
        {2'd0, 3'd4, 32'h0000_00FF, 32'hA5A5_0001, 6'h00, 1'b0}, // R9 clear all
        {2'd0, 3'd0, 32'h0000_0001, 32'hA5A5_0001, 6'h00, 1'b1}, // R6 run
        {2'd1, 3'd0, 32'h0,         32'hA5A5_0001, 6'h20, 1'b1}, // R6 vsync
        {2'd0, 3'd2, 32'h0000_BEEF, 32'hA5A5_0001, 6'h20, 1'b1}, // R4 stage
        {2'd0, 3'd0, 32'h0000_0004, 32'hA5A5_0001, 6'h20, 1'b1}, // R4 pending
        {2'd1, 3'd0, 32'h0,         32'h0000_BEEF, 6'h30, 1'b1}, // R4 swap
        {2'd3, 3'd0, 32'h0,         32'h0000_BEEF, 6'h34, 1'b1}, // R8 underflow
        {2'd2, 3'd0, 32'h0,         32'h0000_BEEF, 6'h36, 1'b1}, // R8 te
        {2'd0, 3'd4, 32'h0000_0006, 32'h0000_BEEF, 6'h30, 1'b1}, // R9 partial
        {2'd0, 3'd0, 32'h0000_0002, 32'h0000_BEEF, 6'h30, 1'b1}, // R6 stop req
        {2'd1, 3'd0, 32'h0,         32'h0000_BEEF, 6'h31, 1'b0}, // R6 stop done
        {2'd0, 3'd4, 32'h0000_00FF, 32'h0000_BEEF, 6'h00, 1'b0}, // R9
        {2'd1, 3'd0, 32'h0,         32'h0000_BEEF, 6'h00, 1'b0}  // R6 idle fe
    };

    logic        clk = 1'b0, rst = 1'b1;
    logic        reg_we = 1'b0, frame_end = 1'b0, te_int = 1'b0, te_pad = 1'b0, underflow = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata, active_cfg;
    logic        irq, scan_on;
    int          checks = 0, errors = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    disp_seq dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_end(frame_end),
        .te_int(te_int), .te_pad(te_pad), .underflow(underflow), .irq(irq),
        .scan_on(scan_on), .active_cfg(active_cfg)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one cycle of stimulus, ending at the following falling edge
    task automatic step(input int op, input logic [2:0] a, input logic [31:0] d,
                        input logic ui, input logic tp);
        @(negedge clk);
        reg_we    = (op == OP_WR);
        reg_addr  = a;
        reg_wdata = d;
        frame_end = (op == OP_FE);
        te_int    = (op == OP_TE);
        underflow = ui;
        te_pad    = tp;
        @(negedge clk);
        reg_we = 1'b0; frame_end = 1'b0; te_int = 1'b0; underflow = 1'b0; te_pad = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        rd(3'd5, rv); chk("R11 status", rv, 32'h0);
        rd(3'd1, rv); chk("R11 mode", rv, 32'h0);
        rd(3'd2, rv); chk("R11 stage", rv, 32'h0);
        rd(3'd3, rv); chk("R11 enable", rv, 32'h0);
        chk("R11 active", active_cfg, 32'h0);
        chk("R11 irq", {31'b0, irq}, 32'h0);
        chk("R11 scan", {31'b0, scan_on}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [75:0] e;
            e = VEC[i];
            step(int'(e[75:74]), e[73:71], e[70:39], e[75:74] == 2'd3, 1'b0);
            rd(3'd5, rv);
            chk($sformatf("R8 vec%0d status", i), rv, {26'b0, e[6:1]});
            chk($sformatf("R4 vec%0d active", i), active_cfg, e[38:7]);
            chk($sformatf("R6 vec%0d scan", i), {31'b0, scan_on}, {31'b0, e[0]});
        end
        rd(3'd0, rv); chk("R1 ctrl readback idle", rv, 32'h0);

        // R10 interrupt masking
        step(OP_UF, 3'd0, 32'h0, 1'b1, 1'b0);
        chk("R10 masked irq", {31'b0, irq}, 32'h0);
        step(OP_WR, 3'd3, 32'h0000_0004, 1'b0, 1'b0);
        chk("R10 enabled irq", {31'b0, irq}, 32'h1);
        step(OP_WR, 3'd4, 32'h0000_0004, 1'b0, 1'b0);
        chk("R10 irq after clear", {31'b0, irq}, 32'h0);
        // R9 event wins over clear in same cycle
        step(OP_WR, 3'd4, 32'h0000_0004, 1'b1, 1'b0);
        rd(3'd5, rv); chk("R9 set beats clear", rv, 32'h4);
        step(OP_WR, 3'd4, 32'h0000_00FF, 1'b0, 1'b0);
        step(OP_WR, 3'd3, 32'h0, 1'b0, 1'b0);

        // command mode, gating off
        step(OP_WR, 3'd1, 32'h1, 1'b0, 1'b0);
        rd(3'd1, rv); chk("R2 mode readback", rv, 32'h1);
        step(OP_WR, 3'd2, 32'h0000_1111, 1'b0, 1'b0);
        chk("R3 stage not active", active_cfg, 32'h0000_BEEF);
        step(OP_WR, 3'd0, 32'h1, 1'b0, 1'b0);
        chk("R3 latch on run", active_cfg, 32'h0000_1111);
        chk("R7 scan on", {31'b0, scan_on}, 32'h1);
        rd(3'd0, rv); chk("R1 ctrl readback busy", rv, 32'h1);
        step(OP_WR, 3'd2, 32'h0000_2222, 1'b0, 1'b0);
        step(OP_WR, 3'd0, 32'h1, 1'b0, 1'b0);
        chk("R3 run in flight ignored", active_cfg, 32'h0000_1111);
        step(OP_WR, 3'd0, 32'h4, 1'b0, 1'b0);
        chk("R12 update ignored", active_cfg, 32'h0000_1111);
        rd(3'd5, rv); chk("R12 no update status", rv, 32'h0);
        step(OP_WR, 3'd0, 32'h2, 1'b0, 1'b0);
        chk("R12 stop ignored", {31'b0, scan_on}, 32'h1);
        step(OP_FE, 3'd0, 32'h0, 1'b0, 1'b0);
        chk("R7 frame done scan", {31'b0, scan_on}, 32'h0);
        rd(3'd5, rv); chk("R7 done status", rv, 32'h1);
        step(OP_WR, 3'd0, 32'h1, 1'b0, 1'b0);
        chk("R3 relatch next run", active_cfg, 32'h0000_2222);
        step(OP_FE, 3'd0, 32'h0, 1'b0, 1'b0);
        step(OP_WR, 3'd4, 32'h0000_00FF, 1'b0, 1'b0);

        // command mode, gating on, pad source
        step(OP_WR, 3'd1, 32'h7, 1'b0, 1'b0);
        step(OP_WR, 3'd0, 32'h1, 1'b0, 1'b0);
        chk("R7 gated wait", {31'b0, scan_on}, 32'h0);
        step(OP_TE, 3'd0, 32'h0, 1'b0, 1'b0);
        chk("R2 internal te ignored", {31'b0, scan_on}, 32'h0);
        rd(3'd5, rv); chk("R2 internal te no status", rv, 32'h0);
        step(OP_WR, 3'd7, 32'h0, 1'b0, 1'b1);
        chk("R7 pad te starts frame", {31'b0, scan_on}, 32'h1);
        rd(3'd5, rv); chk("R8 pad te status", rv, 32'h2);
        step(OP_FE, 3'd0, 32'h0, 1'b0, 1'b0);
        rd(3'd5, rv); chk("R7 gated done", rv, 32'h3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule